// File: doc/BRIEF.md
# MDIO Management Register Controller

This block gives software a register-level path to the management pins of an Ethernet PHY. Software places a complete clause-22 management frame in one 32-bit command register. The block then clocks that frame out on the serial management pair. Before the frame it sends a run of preamble bits held at logic one. The management clock is made by dividing the block clock by a parameter, which defaults to 48. At that ratio the management clock stays within its legal range for block clocks up to 120 MHz.

For a read, the block stops driving the data line at the turnaround field. It then shifts in the sixteen bits the PHY returns, sampling each one on a rising edge of the management clock. When the frame ends, those bits replace the low half of the command register. An idle flag in the status register tells software when a new command may be written. A command is accepted only while a management enable bit in the control register is set. The data line is brought out as three separate signals (output value, output enable and input) so that a pad cell outside the block can build the tri-state pin.

Top module: `mdio_mgmt`

## Requirements
- R1: After reset the control register reads 0, the command register reads 0, the status register reads 32'h4 (idle), `mdc` is low and `mdio_oe` is low.
- R2: A write to the command register (address 2) is accepted only while control bit 4 is 1 and the unit is idle. The idle flag (status bit 2, address 1) reads 0 from the first cycle after the accepted write.
- R3: While a frame runs, every bit lasts MDC_DIV clocks: `mdc` is low for the first MDC_DIV/2 of them and high for the rest. `mdc` is low whenever the unit is idle.
- R4: A frame consists of PRE_LEN bits driven to 1, then command bits 31 down to 0, most significant first. Each new bit appears at the start of a bit period, while `mdc` is low. The command word carries start 01 in bits 31:30, read in bit 29, write in bit 28, the PHY address in bits 27:23, the register number in bits 22:18, turnaround 10 in bits 17:16 and write data in bits 15:0.
- R5: When command bit 29 is 1, `mdio_oe` falls at the turnaround (command bit 17) and stays low to the end of the frame. Otherwise `mdio_oe` stays high for the whole frame.
- R6: In a read, `mdio_in` is sampled in the last low clock before each rising `mdc` edge of command bits 15..0. These samples are taken most significant first and replace command bits 15:0 when the frame ends. Bits 31:16 are unchanged.
- R7: A read from an address where no PHY answers returns 16'hFFFF in bits 15:0, because the line floats high.
- R8: The idle flag returns to 1 exactly (PRE_LEN+32)*MDC_DIV clocks after the edge that accepted the command.
- R9: A command write while a frame is running has no effect: the command register and the frame in progress are unchanged.
- R10: A command write while control bit 4 is 0 is ignored. Clearing bit 4 during a frame ends it: one cycle later the idle flag is 1, `mdc` is low and `mdio_oe` is low.
- R11: Address 0 reads back the enable in bit 4 and zero elsewhere. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 command |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Value driven onto the management data line |
| mdio_oe | output | 1 | Drive enable for the management data line |
| mdio_in | input | 1 | Level sensed on the management data line |

## Verification
On every cycle the assertions check the following:
- the line is quiet while idle;
- the preamble is driven high;
- the line is released for the turnaround and data field of a read, and driven for the whole of a write;
- busy follows one cycle after an accepted command;
- the upper command half is stable across writes made while busy;
- a cleared enable leads to idle.

Other properties can only be shown by the bench's scenarios, where a behavioural model of the frame timing and a model PHY run beside the block:
- the exact bit order on the line;
- the length of the clock halves;
- the cycle on which the idle flag returns;
- the captured data, both for a PHY that answers and for an empty address;
- the effect of an abort on a frame that has already started.

// File: rtl/mdio_mgmt_pkg.sv
`timescale 1ns/1ps
package mdio_mgmt_pkg;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_CMD  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  localparam int CMD_W         = 32;
  localparam int DATA_W        = 16;
  localparam int CTRL_EN_BIT   = 4;
  localparam int STAT_IDLE_BIT = 2;
  localparam int CMD_RD_BIT    = 29;
  // offset inside the command word where the turnaround field starts
  localparam int TA_OFFSET     = 14;
  // offset inside the command word where the data field starts
  localparam int DATA_OFFSET   = 16;

  function automatic int frame_bits(int pre);
    return pre + CMD_W;
  endfunction

  // level on the line for frame position idx
  function automatic logic frame_level(logic [CMD_W-1:0] cmd, int idx, int pre);
    if (idx < pre) return 1'b1;
    return cmd[5'(CMD_W - 1 - (idx - pre))];
  endfunction

  // whether the block drives the line at frame position idx
  function automatic logic frame_drives(logic [CMD_W-1:0] cmd, int idx, int pre);
    return !(cmd[CMD_RD_BIT] && (idx >= pre + TA_OFFSET));
  endfunction

  // whether frame position idx carries read data from the PHY
  function automatic logic frame_captures(logic [CMD_W-1:0] cmd, int idx, int pre);
    return cmd[CMD_RD_BIT] && (idx >= pre + DATA_OFFSET);
  endfunction

endpackage

// File: rtl/mdio_clkdiv.sv
`timescale 1ns/1ps
module mdio_clkdiv #(
  parameter int DIV = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic halt,
  output logic mdc,
  output logic rise_tick,
  output logic bit_end
);
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;

  logic [CW-1:0] phase;

  assign bit_end   = run && (phase == CW'(DIV - 1));
  assign rise_tick = run && (phase == CW'(HALF - 1));
  assign mdc       = run && (phase >= CW'(HALF));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       phase <= '0;
    else if (!run || halt || bit_end) phase <= '0;
    else                              phase <= phase + 1'b1;
  end
endmodule

// File: rtl/mdio_frame_seq.sv
`timescale 1ns/1ps
module mdio_frame_seq
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int IW      = $clog2(PRE_LEN + 32)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              halt,
  input  logic [CMD_W-1:0]  cmd,
  input  logic              rise_tick,
  input  logic              bit_end,
  input  logic              mdio_in,
  output logic              busy,
  output logic [IW-1:0]     bit_idx,
  output logic              mdio_out,
  output logic              mdio_oe,
  output logic              rd_done,
  output logic [DATA_W-1:0] rd_data
);
  localparam int LAST = PRE_LEN + CMD_W - 1;

  logic [DATA_W-1:0] rx_sr;
  logic              last_bit;
  logic              capture;

  assign last_bit = (bit_idx == IW'(LAST));
  assign capture  = busy && !halt && rise_tick &&
                    frame_captures(cmd, int'(bit_idx), PRE_LEN);
  assign rd_done  = busy && !halt && bit_end && last_bit && cmd[CMD_RD_BIT];
  assign rd_data  = rx_sr;
  assign mdio_oe  = busy && frame_drives(cmd, int'(bit_idx), PRE_LEN);
  assign mdio_out = busy && frame_level(cmd, int'(bit_idx), PRE_LEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      bit_idx <= '0;
      rx_sr   <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      bit_idx <= '0;
      rx_sr   <= '0;
    end else if (busy) begin
      if (halt) begin
        busy <= 1'b0;
      end else begin
        if (capture) rx_sr <= {rx_sr[DATA_W-2:0], mdio_in};
        if (bit_end) begin
          if (last_bit) busy    <= 1'b0;
          else          bit_idx <= bit_idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_regfile.sv
`timescale 1ns/1ps
module mdio_regfile
  import mdio_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              busy,
  input  logic              rd_done,
  input  logic [DATA_W-1:0] rd_data,
  output logic              ctrl_en,
  output logic [CMD_W-1:0]  cmd_q,
  output logic              start,
  output logic              halt,
  output logic [31:0]       reg_rdata
);
  assign start = reg_wr && (reg_addr == REG_CMD) && ctrl_en && !busy;
  assign halt  = busy && !ctrl_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en <= 1'b0;
      cmd_q   <= '0;
    end else begin
      if (reg_wr && (reg_addr == REG_CTRL)) ctrl_en <= reg_wdata[CTRL_EN_BIT];
      if (start)        cmd_q               <= reg_wdata;
      else if (rd_done) cmd_q[DATA_W-1:0]   <= rd_data;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      REG_CTRL: reg_rdata[CTRL_EN_BIT]   = ctrl_en;
      REG_STAT: reg_rdata[STAT_IDLE_BIT] = !busy;
      REG_CMD:  reg_rdata                = cmd_q;
      default:  reg_rdata                = '0;
    endcase
  end
endmodule

// File: rtl/mdio_mgmt.sv
`timescale 1ns/1ps
module mdio_mgmt
  import mdio_mgmt_pkg::*;
#(
  parameter int MDC_DIV = 48,
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in
);
  localparam int IW = $clog2(PRE_LEN + CMD_W);

  logic              busy;
  logic              start;
  logic              halt;
  logic              ctrl_en;
  logic [CMD_W-1:0]  cmd_q;
  logic              rise_tick;
  logic              bit_end;
  logic              rd_done;
  logic [DATA_W-1:0] rd_data;
  logic [IW-1:0]     bit_idx;

  mdio_regfile u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .busy      (busy),
    .rd_done   (rd_done),
    .rd_data   (rd_data),
    .ctrl_en   (ctrl_en),
    .cmd_q     (cmd_q),
    .start     (start),
    .halt      (halt),
    .reg_rdata (reg_rdata)
  );

  mdio_clkdiv #(.DIV(MDC_DIV)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy),
    .halt      (halt),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .bit_end   (bit_end)
  );

  mdio_frame_seq #(.PRE_LEN(PRE_LEN), .IW(IW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .halt      (halt),
    .cmd       (cmd_q),
    .rise_tick (rise_tick),
    .bit_end   (bit_end),
    .mdio_in   (mdio_in),
    .busy      (busy),
    .bit_idx   (bit_idx),
    .mdio_out  (mdio_out),
    .mdio_oe   (mdio_oe),
    .rd_done   (rd_done),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/mdio_mgmt_checker.sv
`timescale 1ns/1ps
module mdio_mgmt_checker #(
  parameter int PRE_LEN = 32,
  parameter int IW      = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          start,
  input logic          ctrl_en,
  input logic [31:0]   cmd_q,
  input logic [IW-1:0] bit_idx,
  input logic          mdc,
  input logic          mdio_out,
  input logic          mdio_oe,
  input logic          reg_wr,
  input logic [1:0]    reg_addr
);
  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  assert_preamble_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && int'(bit_idx) < PRE_LEN) |-> (mdio_oe && mdio_out));

  assert_read_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_q[29] && int'(bit_idx) >= PRE_LEN + 14) |-> !mdio_oe);

  assert_write_drives_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cmd_q[29]) |-> mdio_oe);

  assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == 2'd2) |=> $stable(cmd_q[31:16]));

  assert_disable_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> !busy);
endmodule

bind mdio_mgmt mdio_mgmt_checker #(.PRE_LEN(PRE_LEN), .IW(IW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .start    (start),
  .ctrl_en  (ctrl_en),
  .cmd_q    (cmd_q),
  .bit_idx  (bit_idx),
  .mdc      (mdc),
  .mdio_out (mdio_out),
  .mdio_oe  (mdio_oe),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr)
);

// File: tb/mdio_mgmt_test.sv
`timescale 1ns/1ps
module mdio_mgmt_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 8;
  localparam int PRE        = 32;
  localparam int NBITS      = PRE + 32;
  localparam int PHY_ADDR   = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  wire  [31:0] reg_rdata;
  wire         mdc, mdio_out, mdio_oe;
  logic        phy_in = 1'b1;
  wire         mdio_in = mdio_oe ? mdio_out : phy_in;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_mgmt #(.MDC_DIV(DIV), .PRE_LEN(PRE)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk_cmd(bit rd, int phy, int regn, logic [15:0] data);
    logic [31:0] w;
    w = 32'h4002_0000;                 // start 01, turnaround 10
    w |= rd ? 32'h2000_0000 : 32'h1000_0000;
    w |= (32'(phy) & 32'h1F) << 23;
    w |= (32'(regn) & 32'h1F) << 18;
    w |= {16'h0, data};
    return w;
  endfunction

  function automatic logic [15:0] phy_value(int regn);
    return 16'h7949 + 16'(regn);
  endfunction

  // behavioural reference model
  bit          m_busy;
  int          m_cyc;
  logic [31:0] m_cmd;
  bit          m_en;
  logic [15:0] m_rx;

  always @(posedge clk) begin : model
    bit take;
    int ph, bi;
    if (!rst_n) begin
      m_busy = 0; m_cyc = 0; m_cmd = '0; m_en = 0; m_rx = '0;
    end else begin
      take = reg_wr && reg_addr == 2'd2 && m_en && !m_busy;
      if (m_busy) begin
        if (!m_en) m_busy = 0;
        else begin
          ph = m_cyc % DIV;
          bi = m_cyc / DIV;
          if (ph == DIV/2 - 1 && m_cmd[29] && bi >= PRE + 16) m_rx = {m_rx[14:0], mdio_in};
          if (ph == DIV - 1 && bi == NBITS - 1) begin
            m_busy = 0;
            if (m_cmd[29]) m_cmd[15:0] = m_rx;
          end
          m_cyc++;
        end
      end
      if (reg_wr && reg_addr == 2'd0) m_en = reg_wdata[4];
      if (take) begin m_cmd = reg_wdata; m_busy = 1; m_cyc = 0; m_rx = '0; end
    end
  end

  // per-cycle comparison, then the PHY model updates its drive
  always begin : compare
    int ph, bi;
    bit e_mdc, e_oe, e_out;
    logic [31:0] e_rd;
    @(posedge clk);
    #(CLK_PERIOD/4);
    ph = m_cyc % DIV;
    bi = m_cyc / DIV;
    if (rst_n && !done) begin
      e_mdc = m_busy && ph >= DIV/2;
      e_oe  = m_busy && !(m_cmd[29] && bi >= PRE + 14);
      e_out = (bi < PRE) ? 1'b1 : m_cmd[31 - (bi - PRE)];
      chk("R3 mdc", 32'(mdc), 32'(e_mdc));
      chk("R5 mdio_oe", 32'(mdio_oe), 32'(e_oe));
      if (e_oe) chk("R4 frame bit", 32'(mdio_out), 32'(e_out));
      case (reg_addr)
        2'd0: begin e_rd = {27'd0, m_en, 4'd0}; chk("R11 ctrl", reg_rdata, e_rd); end
        2'd1: begin e_rd = {29'd0, !m_busy, 2'd0}; chk("R8 status", reg_rdata, e_rd); end
        2'd2: chk("R6 cmd", reg_rdata, m_cmd);
        default: chk("R11 unused", reg_rdata, 32'd0);
      endcase
    end
    phy_in = 1'b1;
    if (m_busy && m_cmd[29] && int'(m_cmd[27:23]) == PHY_ADDR) begin
      if (bi == PRE + 15) phy_in = 1'b0;
      else if (bi >= PRE + 16) phy_in = phy_value(int'(m_cmd[22:18]))[15 - (bi - PRE - 16)];
    end
  end

  task automatic bus_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 4000; i++) begin
      rd(2'd1, s);
      if (s[2]) return;
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL R8 watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    logic [31:0] v, c;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 32'h0);
    rd(2'd1, v); chk("R1 status", v, 32'h4);
    rd(2'd2, v); chk("R1 cmd", v, 32'h0);
    chk("R1 mdc", 32'(mdc), 32'h0);
    chk("R1 oe", 32'(mdio_oe), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: command while disabled is ignored
    bus_write(2'd2, mk_cmd(1, PHY_ADDR, 1, 16'h0));
    rd(2'd1, v); chk("R10 idle when disabled", v, 32'h4);
    rd(2'd2, v); chk("R10 cmd unchanged", v, 32'h0);

    // R11 control readback
    bus_write(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); chk("R11 ctrl readback", v, 32'h10);
    rd(2'd3, v); chk("R11 addr3", v, 32'h0);

    // write frame, with an ignored command mid-frame (R2, R9)
    c = mk_cmd(0, PHY_ADDR, 4, 16'hC3A5);
    bus_write(2'd2, c);
    rd(2'd1, v); chk("R2 busy after write", v, 32'h0);
    repeat (100) @(negedge clk);
    bus_write(2'd2, mk_cmd(1, 3, 7, 16'h0));
    rd(2'd2, v); chk("R9 cmd unchanged", v, c);
    wait_idle();
    rd(2'd2, v); chk("R9 cmd after frame", v, c);

    // read from present PHY, exact idle timing (R6, R8)
    c = mk_cmd(1, PHY_ADDR, 1, 16'h0);
    bus_write(2'd2, c);
    rd(2'd1, v); chk("R2 busy after read cmd", v, 32'h0);
    repeat (NBITS*DIV - 1) @(negedge clk);
    rd(2'd1, v); chk("R8 still busy", v, 32'h0);
    @(negedge clk);
    rd(2'd1, v); chk("R8 idle on time", v, 32'h4);
    rd(2'd2, v); chk("R6 read data", v, {c[31:16], 16'h794A});

    // R7 absent PHY
    c = mk_cmd(1, 9, 2, 16'h1111);
    bus_write(2'd2, c);
    wait_idle();
    rd(2'd2, v); chk("R7 absent PHY", v, {c[31:16], 16'hFFFF});

    // R6 another register
    c = mk_cmd(1, PHY_ADDR, 31, 16'h0);
    bus_write(2'd2, c);
    wait_idle();
    rd(2'd2, v); chk("R6 read reg31", v, {c[31:16], 16'h7968});

    // R10 abort mid-frame
    c = mk_cmd(1, PHY_ADDR, 3, 16'hBEEF);
    bus_write(2'd2, c);
    repeat (200) @(negedge clk);
    bus_write(2'd0, 32'h0);
    @(negedge clk);
    rd(2'd1, v); chk("R10 idle after abort", v, 32'h4);
    chk("R10 mdc low", 32'(mdc), 32'h0);
    chk("R10 oe low", 32'(mdio_oe), 32'h0);
    rd(2'd2, v); chk("R10 cmd kept", v, c);

    // re-enable and send another write pattern
    bus_write(2'd0, 32'h10);
    c = mk_cmd(0, 31, 0, 16'h5A0F);
    bus_write(2'd2, c);
    wait_idle();
    rd(2'd2, v); chk("R4 cmd after write", v, c);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule